// File: doc/BRIEF.md
# Time-Count Event, Alarm and Trigger Capture Unit

This unit watches a free-running 64-bit time count supplied by a neighbouring timer. It has three jobs. It raises an alarm event when the count reaches either of two programmable 64-bit alarm values. It stamps the count into a per-trigger register on a selected edge of either of two asynchronous trigger inputs. It gathers these events, and three periodic-pulse strobes from another block, into one sticky event register that drives a single maskable interrupt line.

Software reaches the unit through a simple word-wide write strobe and a combinational read port. The interrupt handler reads the event register, reads any captured stamps, and then writes ones to the bits it has handled. Each alarm also drives an output pin whose active level is programmable.

Top module: `tmr_evt_unit`

## Requirements
- R1: Register addresses are: 0 control, 1 event, 2 mask, 4/5 alarm-1 low/high word, 6/7 alarm-2 low/high word, 8/9 trigger-1 stamp low/high, 10/11 trigger-2 stamp low/high. Every other address reads as zero. The event and mask registers keep only bits 25, 24, 17, 16, 7, 6 and 5, so a mask write of all ones reads back 0x030300E0.
- R2: Event bit positions: trigger 2 capture at 25, trigger 1 capture at 24, alarm 2 at 17, alarm 1 at 16, periodic pulse 1, 2 and 3 strobes at 7, 6 and 5. A strobe sets its bit at the next clock edge.
- R3: An event bit stays set until software writes a 1 to that position of the event register. Zeros in the write data leave their bits unchanged.
- R4: When hardware sets an event bit in the same cycle that software clears it, the bit ends up set.
- R5: The mask register uses the event bit positions. `irq` is high exactly when some event bit and its mask bit are both set.
- R6: An armed alarm fires on the cycle in which the count moves from below its value to equal to or above it. Steps larger than one and carries into the high word are included. A count that is already at or past the value when the alarm is armed does not fire.
- R7: An alarm fires at most once for each time it is armed. After it fires, further counting does not set its event again.
- R8: Writing an alarm's low word disarms it. Writing its high word arms it. A disarmed alarm never fires.
- R9: Each trigger input passes through a two-flop synchronizer. The edge sets the capture event and stores the count in the stamp register at the third clock edge after the input changes.
- R10: Control bit 8 (trigger 1) and bit 9 (trigger 2) choose the capture edge: 0 for rising, 1 for falling. The other edge captures nothing.
- R11: A new capture overwrites the stamp even if its event bit is still set.
- R12: `alarm_pin[0]` equals event bit 16 XOR control bit 31. `alarm_pin[1]` equals event bit 17 XOR control bit 30.
- R13: After reset, the control, event and mask registers, `irq` and both alarm pins are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_cnt | input | 64 | Current time count |
| trig_in | input | 2 | Asynchronous external triggers (bit 0 is trigger 1) |
| pulse_in | input | 3 | Periodic-pulse strobes (bit 0 is pulse 1) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational |
| alarm_pin | output | 2 | Alarm outputs with programmable polarity |
| irq | output | 1 | Masked interrupt |

## Verification
A table of alarm cases moves the count in different ways relative to the alarm value: an exact unit-step hit, a large step that jumps over the value, a start already past the value, a carry from low to high word, equal low words with different high words, and a stopped count. These cases separate a crossing detector from an equality or plain greater-or-equal test. Every case that fires is then stepped further to show that it fires only once. Directed sequences exercise half-written alarms, each capture polarity, overwrite of a pending stamp, and a clear that collides with a set. Exact full-register event values confirm the bit layout.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int N_ALARM  = 2;
    localparam int N_TRIG   = 2;
    localparam int N_PULSE  = 3;

    // event bit positions; software decodes these
    localparam int EVB_TRIG_BASE  = 24;   // trigger i -> 24 + i
    localparam int EVB_ALM_BASE   = 16;   // alarm i   -> 16 + i
    localparam int EVB_PULSE_TOP  = 7;    // pulse i   -> 7 - i

    // control bit positions
    localparam int CTL_TRIG_POL_BASE = 8;   // trigger i polarity -> 8 + i
    localparam int CTL_ALM_POL_TOP   = 31;  // alarm i pin polarity -> 31 - i

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_EVENT = 4'd1;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'd2;

    function automatic logic [ADDR_W-1:0] alm_lo_addr(input int i);
        return ADDR_W'(4 + 2 * i);
    endfunction

    function automatic logic [ADDR_W-1:0] alm_hi_addr(input int i);
        return ADDR_W'(5 + 2 * i);
    endfunction

    function automatic logic [ADDR_W-1:0] ts_lo_addr(input int i);
        return ADDR_W'(8 + 2 * i);
    endfunction

    function automatic logic [ADDR_W-1:0] ts_hi_addr(input int i);
        return ADDR_W'(9 + 2 * i);
    endfunction

    function automatic logic [REG_W-1:0] evt_valid_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_TRIG; i++)  m[EVB_TRIG_BASE + i] = 1'b1;
        for (int i = 0; i < N_ALARM; i++) m[EVB_ALM_BASE + i] = 1'b1;
        for (int i = 0; i < N_PULSE; i++) m[EVB_PULSE_TOP - i] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_valid_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_TRIG; i++)  m[CTL_TRIG_POL_BASE + i] = 1'b1;
        for (int i = 0; i < N_ALARM; i++) m[CTL_ALM_POL_TOP - i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tmr_alarm_cmp.sv
module tmr_alarm_cmp #(
    parameter  int RW = 32,
    localparam int TW = 2 * RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cnt_i,
    input  logic [TW-1:0] cnt_prev_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [RW-1:0] wdata_i,
    output logic [TW-1:0] value_o,
    output logic          hit_o
);
    typedef struct packed {
        logic [TW-1:0] value;
        logic          armed;
    } alm_st_t;

    alm_st_t st_d, st_q;

    always_comb begin
        // crossing test: previous count below, current at or above
        hit_o = st_q.armed && (cnt_i >= st_q.value) && (cnt_prev_i < st_q.value);
        st_d  = st_q;
        if (hit_o) begin
            st_d.armed = 1'b0;
        end
        if (wr_lo_i) begin
            st_d.value[RW-1:0] = wdata_i;
            st_d.armed         = 1'b0;
        end
        if (wr_hi_i) begin
            st_d.value[TW-1:RW] = wdata_i;
            st_d.armed          = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.value;
endmodule

// File: rtl/tmr_trig_capture.sv
module tmr_trig_capture #(
    parameter  int RW          = 32,
    parameter  int SYNC_STAGES = 2,
    localparam int TW          = 2 * RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic          fall_sel_i,
    input  logic [TW-1:0] cnt_i,
    output logic [TW-1:0] stamp_o,
    output logic          cap_o
);
    typedef struct packed {
        logic [SYNC_STAGES:0] chain;
        logic [TW-1:0]        stamp;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    synced, hist;

    always_comb begin
        synced = st_q.chain[SYNC_STAGES-1];
        hist   = st_q.chain[SYNC_STAGES];
        cap_o  = fall_sel_i ? (hist & ~synced) : (synced & ~hist);
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-1:0], trig_i};
        if (cap_o) begin
            st_d.stamp = cnt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stamp_o = st_q.stamp;
endmodule

// File: rtl/tmr_evt_reg.sv
module tmr_evt_reg #(
    parameter int              RW    = 32,
    parameter logic [RW-1:0]   VALID = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] set_i,
    input  logic          clr_we_i,
    input  logic          mask_we_i,
    input  logic [RW-1:0] wdata_i,
    output logic [RW-1:0] evt_o,
    output logic [RW-1:0] mask_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [RW-1:0] evt;
        logic [RW-1:0] mask;
    } ev_st_t;

    ev_st_t        st_d, st_q;
    logic [RW-1:0] clr_bits;

    always_comb begin
        clr_bits = clr_we_i ? wdata_i : '0;
        st_d     = st_q;
        // set after clear: a same-cycle set survives
        st_d.evt = ((st_q.evt & ~clr_bits) | set_i) & VALID;
        if (mask_we_i) begin
            st_d.mask = wdata_i & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o  = st_q.evt;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.evt & st_q.mask);
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
    import tmr_evt_pkg::*;
#(
    parameter  int RW          = REG_W,
    parameter  int SYNC_STAGES = 2,
    localparam int TW          = 2 * RW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     time_cnt,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [N_PULSE-1:0] pulse_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [RW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RW-1:0]     rd_data,
    output logic [N_ALARM-1:0] alarm_pin,
    output logic              irq
);
    localparam logic [RW-1:0] EVT_VALID  = RW'(evt_valid_bits());
    localparam logic [RW-1:0] CTRL_VALID = RW'(ctrl_valid_bits());

    typedef struct packed {
        logic [RW-1:0] ctrl;
        logic [TW-1:0] cnt_prev;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [N_ALARM-1:0]         alm_hit;
    logic [N_ALARM-1:0][TW-1:0] alm_val;
    logic [N_TRIG-1:0]          trig_cap;
    logic [N_TRIG-1:0][TW-1:0]  ts_val;
    logic [RW-1:0]              evt_set;
    logic [RW-1:0]              evt_q;
    logic [RW-1:0]              mask_q;
    logic                       clr_we, mask_we;

    always_comb begin
        st_d          = st_q;
        st_d.cnt_prev = time_cnt;
        if (wr_en && wr_addr == A_CTRL) begin
            st_d.ctrl = wr_data & CTRL_VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
            tmr_alarm_cmp #(.RW(RW)) u_alarm (
                .clk       (clk),
                .rst_n     (rst_n),
                .cnt_i     (time_cnt),
                .cnt_prev_i(st_q.cnt_prev),
                .wr_lo_i   (wr_en && wr_addr == alm_lo_addr(i)),
                .wr_hi_i   (wr_en && wr_addr == alm_hi_addr(i)),
                .wdata_i   (wr_data),
                .value_o   (alm_val[i]),
                .hit_o     (alm_hit[i])
            );
            assign alarm_pin[i] = evt_q[EVB_ALM_BASE + i] ^ st_q.ctrl[CTL_ALM_POL_TOP - i];
        end

        for (genvar i = 0; i < N_TRIG; i++) begin : g_trig
            tmr_trig_capture #(.RW(RW), .SYNC_STAGES(SYNC_STAGES)) u_trig (
                .clk       (clk),
                .rst_n     (rst_n),
                .trig_i    (trig_in[i]),
                .fall_sel_i(st_q.ctrl[CTL_TRIG_POL_BASE + i]),
                .cnt_i     (time_cnt),
                .stamp_o   (ts_val[i]),
                .cap_o     (trig_cap[i])
            );
        end
    endgenerate

    always_comb begin
        evt_set = '0;
        for (int i = 0; i < N_ALARM; i++) evt_set[EVB_ALM_BASE + i]  = alm_hit[i];
        for (int i = 0; i < N_TRIG; i++)  evt_set[EVB_TRIG_BASE + i] = trig_cap[i];
        for (int i = 0; i < N_PULSE; i++) evt_set[EVB_PULSE_TOP - i] = pulse_in[i];
    end

    assign clr_we  = wr_en && wr_addr == A_EVENT;
    assign mask_we = wr_en && wr_addr == A_MASK;

    tmr_evt_reg #(.RW(RW), .VALID(EVT_VALID)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_set),
        .clr_we_i (clr_we),
        .mask_we_i(mask_we),
        .wdata_i  (wr_data),
        .evt_o    (evt_q),
        .mask_o   (mask_q),
        .irq_o    (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)  rd_data = st_q.ctrl;
        if (rd_addr == A_EVENT) rd_data = evt_q;
        if (rd_addr == A_MASK)  rd_data = mask_q;
        for (int i = 0; i < N_ALARM; i++) begin
            if (rd_addr == alm_lo_addr(i)) rd_data = alm_val[i][RW-1:0];
            if (rd_addr == alm_hi_addr(i)) rd_data = alm_val[i][TW-1:RW];
        end
        for (int i = 0; i < N_TRIG; i++) begin
            if (rd_addr == ts_lo_addr(i)) rd_data = ts_val[i][RW-1:0];
            if (rd_addr == ts_hi_addr(i)) rd_data = ts_val[i][TW-1:RW];
        end
    end
endmodule

// File: rtl/tmr_evt_unit_chk.sv
module tmr_evt_unit_chk
    import tmr_evt_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [63:0]          time_cnt,
    input logic                 irq,
    input logic [31:0]          evt_q,
    input logic [31:0]          mask_q,
    input logic [1:0]           alm_hit,
    input logic [1:0]           trig_cap,
    input logic [1:0][63:0]     ts_val
);
    // R3: with no event-register write, no set bit drops
    assert_evt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_EVENT) |=> ((evt_q & $past(evt_q)) == $past(evt_q)))
        else $error("event bit dropped without a clear write");

    // R5: nothing masked in, no interrupt
    assert_irq_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 32'd0) |-> !irq)
        else $error("irq with empty mask");

    generate
        for (genvar i = 0; i < 2; i++) begin : g_chk
            // R4: a hit always lands in the event register, even against a clear
            assert_hit_sets_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
                alm_hit[i] |=> evt_q[EVB_ALM_BASE + i])
                else $error("alarm hit lost");

            // R7: no second hit without re-arming
            assert_alarm_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (alm_hit[i] && !(wr_en && wr_addr == alm_hi_addr(i))) |=> !alm_hit[i])
                else $error("alarm hit twice");

            // R8: low-word write leaves the alarm unable to hit
            assert_lo_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == alm_lo_addr(i)) |=> !alm_hit[i])
                else $error("alarm hit after low-word write");

            // R9: capture stores the count and flags the event
            assert_capture_stamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
                trig_cap[i] |=> (ts_val[i] == $past(time_cnt)) && evt_q[EVB_TRIG_BASE + i])
                else $error("capture did not stamp the count");
        end
    endgenerate
endmodule

bind tmr_evt_unit tmr_evt_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .time_cnt(time_cnt),
    .irq     (irq),
    .evt_q   (evt_q),
    .mask_q  (mask_q),
    .alm_hit (alm_hit),
    .trig_cap(trig_cap),
    .ts_val  (ts_val)
);

// File: tb/tmr_evt_unit_bench.sv
module tmr_evt_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_cnt = '0;
    logic [1:0]  trig_in = '0;
    logic [2:0]  pulse_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  alarm_pin;
    logic        irq;

    int checks = 0;
    int errs   = 0;
    logic [31:0] d;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_evt_unit u_tmr_evt_unit (
        .clk(clk), .rst_n(rst_n), .time_cnt(time_cnt), .trig_in(trig_in),
        .pulse_in(pulse_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .alarm_pin(alarm_pin), .irq(irq)
    );

    typedef struct packed {
        logic [63:0] val;
        logic [63:0] start;
        logic [63:0] step;
        logic        fire;
    } vec_t;

    // alarm-1 crossing cases (R6)
    localparam vec_t VEC [6] = '{
        '{64'd100,            64'd95,            64'd1, 1'b1},
        '{64'd100,            64'd90,            64'd7, 1'b1},
        '{64'd100,            64'd200,           64'd1, 1'b0},
        '{64'h1_0000_0005,    64'h0_FFFF_FFFE,   64'd3, 1'b1},
        '{64'h1_0000_0005,    64'd5,             64'd1, 1'b0},
        '{64'd1000,           64'd990,           64'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [2:0] p);
        @(negedge clk) pulse_in = p;
        @(negedge clk) pulse_in = '0;
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(1);

        // R13 / R1: reset state and unused address
        rd(4'd0, d); chk("R13 ctrl", d, 0);
        rd(4'd1, d); chk("R13 event", d, 0);
        rd(4'd2, d); chk("R13 mask", d, 0);
        chk("R13 irq", irq, 0);
        chk("R13 pins", alarm_pin, 0);
        rd(4'd3, d); chk("R1 unused addr", d, 0);

        // R6 / R7: table of crossing cases on alarm 1
        for (int k = 0; k < 6; k++) begin
            wr(4'd4, VEC[k].val[31:0]);
            @(negedge clk) time_cnt = VEC[k].start;
            ticks(1);
            wr(4'd5, VEC[k].val[63:32]);
            wr(4'd1, 32'h0001_0000);
            for (int s = 0; s < 8; s++) begin
                @(negedge clk) time_cnt = time_cnt + VEC[k].step;
            end
            ticks(2);
            rd(4'd1, d); chk($sformatf("R6 case %0d", k), d[16], VEC[k].fire);
            if (VEC[k].fire) begin
                wr(4'd1, 32'h0001_0000);
                for (int s = 0; s < 8; s++) begin
                    @(negedge clk) time_cnt = time_cnt + VEC[k].step;
                end
                ticks(2);
                rd(4'd1, d); chk($sformatf("R7 once case %0d", k), d[16], 0);
            end
        end
        rd(4'd4, d); chk("R1 alarm1 lo readback", d, 32'd1000);

        // R8: low write alone leaves alarm disarmed
        wr(4'd4, 32'd50);
        @(negedge clk) time_cnt = 64'd40;
        @(negedge clk) time_cnt = 64'd60;
        ticks(2);
        rd(4'd1, d); chk("R8 half-written no fire", d[16], 0);
        wr(4'd5, 32'd0);
        @(negedge clk) time_cnt = 64'd40;
        @(negedge clk) time_cnt = 64'd60;
        ticks(2);
        rd(4'd1, d); chk("R8 armed fires", d, 32'h0001_0000);

        // R12: alarm pin polarity
        chk("R12 pin0 active high", alarm_pin[0], 1);
        wr(4'd0, 32'h8000_0000);
        chk("R12 pin0 inverted", alarm_pin[0], 0);
        chk("R12 pin1 idle", alarm_pin[1], 0);
        wr(4'd0, 32'hC000_0000);
        chk("R12 pin1 inverted idle", alarm_pin[1], 1);
        wr(4'd0, 32'h0);

        // R5: interrupt masking
        chk("R5 irq no mask", irq, 0);
        wr(4'd2, 32'h0002_0000);
        chk("R5 irq other bit masked", irq, 0);
        wr(4'd2, 32'h0001_0000);
        chk("R5 irq matched", irq, 1);
        wr(4'd1, 32'h0001_0000);
        chk("R5 irq after clear", irq, 0);
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, d); chk("R1 mask valid bits", d, 32'h0303_00E0);
        wr(4'd2, 32'h0);

        // R2: alarm 2 position
        wr(4'd6, 32'd500);
        wr(4'd7, 32'd0);
        @(negedge clk) time_cnt = 64'd490;
        @(negedge clk) time_cnt = 64'd510;
        ticks(2);
        rd(4'd1, d); chk("R2 alarm2 bit17", d, 32'h0002_0000);
        wr(4'd1, 32'hFFFF_FFFF);

        // R2: pulse positions
        strobe(3'b001); rd(4'd1, d); chk("R2 pulse1 bit7", d, 32'h80);
        wr(4'd1, 32'h80);
        strobe(3'b010); rd(4'd1, d); chk("R2 pulse2 bit6", d, 32'h40);
        wr(4'd1, 32'h40);
        strobe(3'b100); rd(4'd1, d); chk("R2 pulse3 bit5", d, 32'h20);
        wr(4'd1, 32'h20);

        // R3: write-one-to-clear
        strobe(3'b111);
        wr(4'd1, 32'h0);
        rd(4'd1, d); chk("R3 zero write no effect", d, 32'hE0);
        wr(4'd1, 32'h40);
        rd(4'd1, d); chk("R3 clear one bit", d, 32'hA0);

        // R4: set wins over clear
        @(negedge clk);
        pulse_in = 3'b001; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h80;
        @(negedge clk);
        pulse_in = '0; wr_en = 1'b0;
        rd(4'd1, d); chk("R4 set wins", d, 32'hA0);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, d); chk("R3 clear all", d, 0);

        // R9: rising capture on trigger 1, latency
        time_cnt = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk) trig_in[0] = 1'b1;
        ticks(2);
        rd(4'd1, d); chk("R9 not before third edge", d[24], 0);
        ticks(1);
        rd(4'd1, d); chk("R9 trig1 bit24", d, 32'h0100_0000);
        rd(4'd8, d); chk("R9 stamp lo", d, 32'h9ABC_DEF0);
        rd(4'd9, d); chk("R9 stamp hi", d, 32'h1234_5678);

        // R11: overwrite while pending; R10: falling edge of trigger 1 ignored
        time_cnt = 64'hAAAA_0000_0000_0005;
        @(negedge clk) trig_in[0] = 1'b0;
        ticks(4);
        rd(4'd8, d); chk("R10 falling ignored in rising mode", d, 32'h9ABC_DEF0);
        @(negedge clk) trig_in[0] = 1'b1;
        ticks(4);
        rd(4'd8, d); chk("R11 overwrite lo", d, 32'h5);
        rd(4'd9, d); chk("R11 overwrite hi", d, 32'hAAAA_0000);
        rd(4'd1, d); chk("R11 event still set", d, 32'h0100_0000);

        // R10: falling-edge mode on trigger 2
        wr(4'd0, 32'h0000_0200);
        @(negedge clk) trig_in[1] = 1'b1;
        ticks(4);
        rd(4'd1, d); chk("R10 rising ignored", d[25], 0);
        time_cnt = 64'd77;
        @(negedge clk) trig_in[1] = 1'b0;
        ticks(4);
        rd(4'd1, d); chk("R10 falling captures bit25", d[25], 1);
        rd(4'd10, d); chk("R10 stamp2 lo", d, 32'd77);
        rd(4'd11, d); chk("R10 stamp2 hi", d, 32'd0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule